// File: doc/BRIEF.md
# One-Time-Programmable Fuse Access Sequencer

This block drives the control pins of a 1024-bit one-time-programmable fuse macro, organised as 32 words of 32 bits. A host starts an operation with a single valid/ready command. The block then runs the whole pin sequence itself and the host does no bit-level timing. A read operation strobes every word in turn and keeps the results in a 32-word shadow buffer, which the host reads through an index port. A program operation scans a 32-word image that the host presents on a word-indexed port. It strobes only the fuse positions whose image bit is 1, and it holds each strobe for a timed programming pulse. Between operations the macro stays deselected and powered down.

All delays are counted in clock cycles. `CLK_MHZ` cycles make one microsecond. The setup wait, the read strobe and the programming pulse are given in microseconds (defaults 1, 1 and 13), so the timing holds at any clock rate.

The controller has seven states:
- `S_IDLE` moves to `S_RD_SETUP` or `S_PG_SETUP` when a command is accepted.
- `S_RD_SETUP` moves to `S_RD_STROBE` when its timer expires.
- `S_RD_STROBE` repeats once per word and moves to `S_FINISH` after the last word.
- `S_PG_SETUP` moves to `S_PG_SCAN` when its timer expires.
- `S_PG_SCAN` moves to `S_PG_STROBE` on a set bit. On a clear bit it advances to the next bit, or moves to `S_FINISH` after the last bit.
- `S_PG_STROBE` returns to `S_PG_SCAN` when the pulse ends, or moves to `S_FINISH` if that was the last bit.
- `S_FINISH` always moves to `S_IDLE`.

Top module: `fuse_seq`

## Requirements
- R1: Out of reset and whenever idle, `fuse_ctrl` equals chip-select-bar (bit 0) plus power-down (bit 5), with every other bit 0 (value 0x21). In this state `cmd_ready`=1, `busy`=0 and `done`=0.
- R2: A command is accepted only on a clock edge where `cmd_valid` and `cmd_ready` are both 1, and `busy` is 1 from the next cycle. A command presented while busy is ignored and changes neither the sequence nor the outputs.
- R3: A read (`cmd_prog`=0) first drives load (bit 2), program-enable-bar (bit 3), reset-bar (bit 7) and strobe-select (bit 9), value 0x28C. It holds this for SETUP_US*CLK_MHZ cycles.
- R4: The read then visits words 0 to 31 in ascending order. For each word it drives the R3 value plus strobe (bit 1) plus the word index in bits 25:16, for READ_US*CLK_MHZ cycles. `fuse_dout` is sampled in the last of those cycles.
- R5: `rd_word` returns the sampled word selected by `rd_idx`. The buffer keeps its contents through a program operation until the next read.
- R6: A program (`cmd_prog`=1) first drives program-select (bit 4), reset-bar and strobe-select, value 0x290, for SETUP_US*CLK_MHZ cycles.
- R7: Programming scans bits with word index outer and bit index inner. It spends exactly one cycle per bit with `fuse_ctrl` at 0x290, and presents the current word index on `img_idx`.
- R8: Only image bits that are 1 are pulsed. For bit j of word i, `fuse_ctrl` is strobe (bit 1) plus address i+32*j in bits 25:16 and nothing else, held for PROG_US*CLK_MHZ cycles. This must be at least 12 us worth of cycles. A zero bit produces no strobe.
- R9: After the last word or bit, `fuse_ctrl` returns to 0x21 with `done`=1 and `busy`=1 for exactly one cycle. The next cycle is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_prog | input | 1 | 1 = program, 0 = read |
| cmd_ready | output | 1 | Block is idle and takes a command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the macro is back in power-down |
| img_idx | output | 5 | Word of the program image being scanned |
| img_word | input | 32 | Image word selected by `img_idx` |
| rd_idx | input | 5 | Shadow buffer read index |
| rd_word | output | 32 | Shadow buffer word at `rd_idx` |
| fuse_ctrl | output | 26 | Macro control word, address in bits 25:16 |
| fuse_dout | input | 32 | Macro data output |

## Verification
The bench builds the block with `CLK_MHZ`=4 and the default 1/1/13 microsecond delays. This gives a 4-cycle setup, a 4-cycle read strobe per word and a 52-cycle programming pulse. At these values a complete read takes about 140 cycles and a full 1024-bit scan with dozens of pulses takes a few thousand cycles. The bench can therefore run several complete reads and programs back to back, including an all-zero image, a fully set word, a bit that is already blown, and the first and last fuse addresses. A fuse stub in the bench blows a bit only when the strobe is held for at least 48 cycles. Reading the fuses back then confirms both the address formula and the pulse length.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

    // Control word bit positions seen by the fuse macro
    localparam int CB_CSB      = 0;
    localparam int CB_STB      = 1;
    localparam int CB_LOAD     = 2;
    localparam int CB_PGENB    = 3;
    localparam int CB_PSEL     = 4;
    localparam int CB_PD       = 5;
    localparam int CB_RSTB     = 7;
    localparam int CB_SSEL     = 9;
    localparam int CB_ADDR_LSB = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_SETUP,
        S_RD_STROBE,
        S_PG_SETUP,
        S_PG_SCAN,
        S_PG_STROBE,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/fuse_seq_timer.sv
module fuse_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len_m1,
    output logic          zero
);

    logic [CW-1:0] cnt_q;

    // Load value N-1 on entry, so a state lasts N cycles ending at zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len_m1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/fuse_seq_cursor.sv
module fuse_seq_cursor #(
    parameter int WIDX_W = 5,
    parameter int BIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step_word,
    input  logic              step_bit,
    output logic [WIDX_W-1:0] word_idx,
    output logic [BIDX_W-1:0] bit_idx,
    output logic              word_last,
    output logic              all_last
);

    localparam logic [WIDX_W-1:0] WORD_MAX = '1;
    localparam logic [BIDX_W-1:0] BIT_MAX  = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_idx <= '0;
            bit_idx  <= '0;
        end else if (clr) begin
            word_idx <= '0;
            bit_idx  <= '0;
        end else if (step_word) begin
            word_idx <= word_idx + 1'b1;
        end else if (step_bit) begin
            // bit index is the inner loop, word index the outer one
            if (bit_idx == BIT_MAX) begin
                bit_idx  <= '0;
                word_idx <= word_idx + 1'b1;
            end else begin
                bit_idx  <= bit_idx + 1'b1;
            end
        end
    end

    assign word_last = (word_idx == WORD_MAX);
    assign all_last  = word_last && (bit_idx == BIT_MAX);

endmodule

// File: rtl/fuse_seq_shadow.sv
module fuse_seq_shadow #(
    parameter int N_WORDS = 32,
    parameter int WORD_W  = 32,
    parameter int WIDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [N_WORDS];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && (wr_idx == WIDX_W'(g)))
                mem[g] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_seq_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int SETUP_US    = 1,
    parameter int READ_US     = 1,
    parameter int PROG_US     = 13,
    parameter int MIN_PROG_US = 12,
    parameter int N_WORDS     = 32,
    parameter int WORD_W      = 32,
    localparam int WIDX_W     = $clog2(N_WORDS),
    localparam int BIDX_W     = $clog2(WORD_W),
    localparam int ADDR_W     = WIDX_W + BIDX_W,
    localparam int CTRL_W     = CB_ADDR_LSB + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_prog,
    output logic              cmd_ready,
    output logic              busy,
    output logic              done,
    output logic [WIDX_W-1:0] img_idx,
    input  logic [WORD_W-1:0] img_word,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [CTRL_W-1:0] fuse_ctrl,
    input  logic [WORD_W-1:0] fuse_dout
);

    localparam int SETUP_CYC = SETUP_US * CLK_MHZ;
    localparam int READ_CYC  = READ_US * CLK_MHZ;
    localparam int PROG_CYC  = PROG_US * CLK_MHZ;
    localparam int MIN_CYC   = MIN_PROG_US * CLK_MHZ;
    localparam int MAX_CYC   = (PROG_CYC > SETUP_CYC) ?
                               ((PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC) :
                               ((SETUP_CYC > READ_CYC) ? SETUP_CYC : READ_CYC);
    localparam int CW        = $clog2(MAX_CYC + 1);
    localparam int PW        = $clog2(PROG_CYC + 2);

    seq_state_e        state_q, state_d;
    logic              tmr_load, tmr_zero;
    logic [CW-1:0]     tmr_len;
    logic              cur_clr, step_word, step_bit;
    logic              word_last, all_last;
    logic [WIDX_W-1:0] word_idx;
    logic [BIDX_W-1:0] bit_idx;
    logic              sh_we;

    fuse_seq_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .len_m1 (tmr_len),
        .zero   (tmr_zero)
    );

    fuse_seq_cursor #(.WIDX_W(WIDX_W), .BIDX_W(BIDX_W)) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cur_clr),
        .step_word (step_word),
        .step_bit  (step_bit),
        .word_idx  (word_idx),
        .bit_idx   (bit_idx),
        .word_last (word_last),
        .all_last  (all_last)
    );

    fuse_seq_shadow #(.N_WORDS(N_WORDS), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (sh_we),
        .wr_idx  (word_idx),
        .wr_data (fuse_dout),
        .rd_idx  (rd_idx),
        .rd_data (rd_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Next state, timer and cursor control
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_len   = '0;
        cur_clr   = 1'b0;
        step_word = 1'b0;
        step_bit  = 1'b0;
        sh_we     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    state_d  = cmd_prog ? S_PG_SETUP : S_RD_SETUP;
                    tmr_load = 1'b1;
                    tmr_len  = CW'(SETUP_CYC - 1);
                    cur_clr  = 1'b1;
                end
            end
            S_RD_SETUP: begin
                if (tmr_zero) begin
                    state_d  = S_RD_STROBE;
                    tmr_load = 1'b1;
                    tmr_len  = CW'(READ_CYC - 1);
                end
            end
            S_RD_STROBE: begin
                if (tmr_zero) begin
                    sh_we = 1'b1;
                    if (word_last) begin
                        state_d = S_FINISH;
                    end else begin
                        step_word = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_len   = CW'(READ_CYC - 1);
                    end
                end
            end
            S_PG_SETUP: begin
                if (tmr_zero)
                    state_d = S_PG_SCAN;
            end
            S_PG_SCAN: begin
                if (img_word[bit_idx]) begin
                    state_d  = S_PG_STROBE;
                    tmr_load = 1'b1;
                    tmr_len  = CW'(PROG_CYC - 1);
                end else if (all_last) begin
                    state_d = S_FINISH;
                end else begin
                    step_bit = 1'b1;
                end
            end
            S_PG_STROBE: begin
                if (tmr_zero) begin
                    if (all_last) begin
                        state_d = S_FINISH;
                    end else begin
                        step_bit = 1'b1;
                        state_d  = S_PG_SCAN;
                    end
                end
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fuse_ctrl = '0;
        unique case (state_q)
            S_IDLE, S_FINISH: begin
                fuse_ctrl[CB_CSB] = 1'b1;
                fuse_ctrl[CB_PD]  = 1'b1;
            end
            S_RD_SETUP, S_RD_STROBE: begin
                fuse_ctrl[CB_LOAD]  = 1'b1;
                fuse_ctrl[CB_PGENB] = 1'b1;
                fuse_ctrl[CB_RSTB]  = 1'b1;
                fuse_ctrl[CB_SSEL]  = 1'b1;
                if (state_q == S_RD_STROBE) begin
                    fuse_ctrl[CB_STB] = 1'b1;
                    fuse_ctrl[CB_ADDR_LSB +: ADDR_W] = {{BIDX_W{1'b0}}, word_idx};
                end
            end
            S_PG_SETUP, S_PG_SCAN: begin
                fuse_ctrl[CB_PSEL] = 1'b1;
                fuse_ctrl[CB_RSTB] = 1'b1;
                fuse_ctrl[CB_SSEL] = 1'b1;
            end
            S_PG_STROBE: begin
                fuse_ctrl[CB_STB] = 1'b1;
                fuse_ctrl[CB_ADDR_LSB +: ADDR_W] = {bit_idx, word_idx};
            end
            default: fuse_ctrl = '0;
        endcase
    end

    assign cmd_ready = (state_q == S_IDLE);
    assign busy      = (state_q != S_IDLE);
    assign done      = (state_q == S_FINISH);
    assign img_idx   = word_idx;

    // Programming pulse length observed at the macro pins
    logic          prog_stb;
    logic [PW-1:0] pulse_len;

    assign prog_stb = fuse_ctrl[CB_STB] && !fuse_ctrl[CB_LOAD];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pulse_len <= '0;
        else if (prog_stb)
            pulse_len <= (pulse_len == '1) ? pulse_len : pulse_len + 1'b1;
        else
            pulse_len <= '0;
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready)); // R9

    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_stb) |-> (pulse_len >= PW'(MIN_CYC))); // R8

    AST_PULSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_stb && $past(prog_stb)) |-> $stable(fuse_ctrl)); // R8

endmodule

// File: tb/fuse_seq_tb.sv
module fuse_seq_tb;

    localparam int MHZ   = 4;
    localparam int SET_C = MHZ * 1;
    localparam int RD_C  = MHZ * 1;
    localparam int PG_C  = MHZ * 13;
    localparam int MIN_C = MHZ * 12;
    localparam logic [25:0] IDLE_V  = 26'h21;
    localparam logic [25:0] RD_BASE = 26'h28C;
    localparam logic [25:0] PG_BASE = 26'h290;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_prog = 1'b0;
    logic        cmd_ready, busy, done;
    logic [4:0]  img_idx;
    logic [31:0] img_word;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_word;
    logic [25:0] fuse_ctrl;
    logic [31:0] fuse_dout;

    logic [31:0] img      [32];
    logic [31:0] fuse_mem [32];
    logic [31:0] exp_fuse [32];
    logic [31:0] sh_exp   [32];

    logic [25:0] q_ctrl [$];
    bit          q_done [$];
    string       q_tag  [$];
    bit          m_idle = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    int          stb_run = 0;
    bit          stb_on = 1'b0;
    logic [9:0]  stb_addr = '0;

    always #2 clk = ~clk;

    assign img_word  = img[img_idx];
    assign fuse_dout = (fuse_ctrl[1] && fuse_ctrl[2] && !fuse_ctrl[0]) ?
                       fuse_mem[fuse_ctrl[20:16]] : 32'hA5A5_5A5A;

    fuse_seq #(.CLK_MHZ(MHZ)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_prog  (cmd_prog),
        .cmd_ready (cmd_ready),
        .busy      (busy),
        .done      (done),
        .img_idx   (img_idx),
        .img_word  (img_word),
        .rd_idx    (rd_idx),
        .rd_word   (rd_word),
        .fuse_ctrl (fuse_ctrl),
        .fuse_dout (fuse_dout)
    );

    function automatic logic [31:0] preset(int w);
        return {w[7:0], 24'h0} | (32'h1 << (w % 7));
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: expected pins every cycle, plus a behavioural fuse stub
    always @(negedge clk) begin
        logic [25:0] ec;
        bit          ed, eb;
        string       et;
        if (!rst_n) begin
            for (int w = 0; w < 32; w++) fuse_mem[w] = preset(w);
            m_idle = 1'b0;
        end else begin
            if (q_ctrl.size() > 0) begin
                ec = q_ctrl.pop_front();
                ed = q_done.pop_front();
                et = q_tag.pop_front();
                eb = 1'b1;
                m_idle = 1'b0;
            end else begin
                ec = IDLE_V; ed = 1'b0; eb = 1'b0; et = "R1"; m_idle = 1'b1;
            end
            chk(fuse_ctrl == ec && done == ed && busy == eb && cmd_ready == !eb, et,
                "ctrl/done/busy/ready", {35'h0, fuse_ctrl, done, busy, cmd_ready},
                {35'h0, ec, ed, eb, !eb});
            if (fuse_ctrl[9:0] == 10'h002) begin
                if (stb_on && fuse_ctrl[25:16] == stb_addr) begin
                    stb_run++;
                end else begin
                    stb_on = 1'b1; stb_addr = fuse_ctrl[25:16]; stb_run = 1;
                end
            end else if (stb_on) begin
                if (stb_run >= MIN_C) fuse_mem[stb_addr[4:0]][stb_addr[9:5]] = 1'b1;
                stb_on = 1'b0;
            end
        end
    end

    task automatic issue(bit prog);
        logic [25:0] v;
        @(negedge clk); #1;
        cmd_prog  = prog;
        cmd_valid = 1'b1;
        if (m_idle) begin
            if (!prog) begin
                for (int i = 0; i < SET_C; i++) begin q_ctrl.push_back(RD_BASE); q_done.push_back(0); q_tag.push_back("R3"); end
                for (int w = 0; w < 32; w++) begin
                    v = RD_BASE | 26'h2;
                    v[25:16] = 10'(w);
                    for (int i = 0; i < RD_C; i++) begin q_ctrl.push_back(v); q_done.push_back(0); q_tag.push_back("R4"); end
                end
            end else begin
                for (int i = 0; i < SET_C; i++) begin q_ctrl.push_back(PG_BASE); q_done.push_back(0); q_tag.push_back("R6"); end
                for (int w = 0; w < 32; w++) begin
                    for (int b = 0; b < 32; b++) begin
                        q_ctrl.push_back(PG_BASE); q_done.push_back(0); q_tag.push_back("R7");
                        if (img[w][b]) begin
                            v = 26'h2;
                            v[25:16] = 10'(w + 32 * b);
                            for (int i = 0; i < PG_C; i++) begin q_ctrl.push_back(v); q_done.push_back(0); q_tag.push_back("R8"); end
                        end
                    end
                    exp_fuse[w] = exp_fuse[w] | img[w];
                end
            end
            q_ctrl.push_back(IDLE_V); q_done.push_back(1); q_tag.push_back("R9");
        end
        @(negedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (q_ctrl.size() != 0) begin @(negedge clk); #1; end
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic check_shadow(string tag);
        for (int w = 0; w < 32; w++) begin
            @(negedge clk); #1;
            rd_idx = 5'(w);
            #1;
            chk(rd_word == sh_exp[w], tag, "shadow word", {32'h0, rd_word}, {32'h0, sh_exp[w]});
        end
    endtask

    task automatic check_fuses(string tag);
        for (int w = 0; w < 32; w++)
            chk(fuse_mem[w] == exp_fuse[w], tag, "fuse array word", {32'h0, fuse_mem[w]}, {32'h0, exp_fuse[w]});
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog expired: actual=hung expected=idle");
        summary();
        $finish;
    end

    initial begin
        for (int w = 0; w < 32; w++) begin
            img[w] = '0;
            exp_fuse[w] = preset(w);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: idle pins right after reset
        #1;
        chk(fuse_ctrl == IDLE_V && cmd_ready && !busy && !done, "R1", "reset state",
            {35'h0, fuse_ctrl, done, busy, cmd_ready}, {35'h0, IDLE_V, 3'b001});

        // R3 R4 R5: read of the factory contents
        issue(1'b0);
        for (int w = 0; w < 32; w++) sh_exp[w] = exp_fuse[w];
        wait_idle();
        check_shadow("R5");

        // R6 R7 R8: program with first and last addresses; R2: read while busy is ignored
        img[0]  = 32'h0000_0001;
        img[31] = 32'h8000_0000;
        img[5]  = 32'h0002_0008;
        img[17] = 32'h0000_0100;
        issue(1'b1);
        repeat (20) @(negedge clk);
        issue(1'b0);
        wait_idle();
        check_fuses("R8");
        check_shadow("R5");

        issue(1'b0);
        for (int w = 0; w < 32; w++) sh_exp[w] = exp_fuse[w];
        wait_idle();
        check_shadow("R4");

        // R7 R8: all-zero image produces a pure scan
        for (int w = 0; w < 32; w++) img[w] = '0;
        issue(1'b1);
        wait_idle();
        check_fuses("R8");

        // R8: fully set word and an already blown bit
        img[9] = 32'hFFFF_FFFF;
        img[0] = 32'h0000_0001;
        issue(1'b1);
        wait_idle();
        check_fuses("R8");
        issue(1'b0);
        for (int w = 0; w < 32; w++) sh_exp[w] = exp_fuse[w];
        wait_idle();
        check_shadow("R5");

        summary();
        $finish;
    end

endmodule